// File: doc/BRIEF.md
# Phase-Interleaved Shared Video RAM Controller

This block lets a CPU and a video fetch unit share one 4K-byte RAM without request arbitration. Each bus cycle of the derived bus clock E is split into two halves. The video side owns the RAM while E is low. The CPU owns it while E is high. A master clock running at 2·HALF_TICKS times the E rate steps a tick counter. E, a narrow timing window inside each half, and the latch strobes for read data are all decoded from that counter.

The CPU address is captured while E is low, whenever the address strobe is high, so it stays steady for the whole high half. Write enable is qualified by the window so that it never becomes active while the address or data could still be settling. The same window qualifies the falling edge of horizontal sync before it reaches the video unit. A falling edge that arrives outside the window waits for the next window. This keeps the video unit's data latching in step with the CPU cycle. The storage is two 2K x 8 banks. Address bit 11 chooses the bank, and one bank is always enabled.

Top module: `shared_vram_ctrl`

## Requirements
- R1: The tick counter runs 0 to 2·HALF_TICKS−1 and restarts at 0 after reset. `e_clk` is 0 for ticks 0..HALF_TICKS−1 and 1 for the rest. With the default HALF_TICKS=4, ticks 0-3 are E low and ticks 4-7 are E high.
- R2: `window` is 1 only at positions 1..HALF_TICKS−2 within each half. With the default this is ticks 1, 2, 5 and 6.
- R3: The RAM address comes from `vid_addr` while E is low and from the latched CPU address while E is high. `ram_cpu_side` is 1 exactly when E is high.
- R4: `cpu_addr` is captured on each master edge that falls in the E-low half while `cpu_as` is 1. Changes to `cpu_addr` during the E-high half do not affect that cycle's access.
- R5: The RAM is two 2K x 8 banks. Address bit 11 selects the bank (0 for the lower bank, 1 for the upper), so locations that differ only in bit 11 hold independent bytes.
- R6: `ram_we_n` is 0 only when E is high, `window` is 1, `cpu_sel` is 1 and `cpu_rw` is 0 (0 means write). A write stores `cpu_wdata` at the latched address.
- R7: When `cpu_sel` is 0, the access leaves the array unchanged, keeps `ram_we_n` at 1 and leaves `cpu_rdata` unchanged.
- R8: `vid_data` is loaded from the RAM at the edge that ends the last E-low tick. The data comes from the location that `vid_addr` addressed during that half.
- R9: For an in-range read (`cpu_sel`=1, `cpu_rw`=1), `cpu_rdata` is loaded at the edge that ends the last E-high tick. At all other times it holds its value. After reset it is 0.
- R10: `hs_n_out` falls only on the edge that ends a tick in which `window` is 1.
- R11: Every falling edge of `hs_n_in` produces exactly one falling edge of `hs_n_out`. An edge that arrives outside the window is held until the next window. `hs_n_out` returns to 1 on the first edge after its fall at which `hs_n_in` is 1. After reset it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, 2·HALF_TICKS times the E rate |
| rst_n | input | 1 | Active-low synchronous reset |
| e_clk | output | 1 | Bus clock E (0 = video half, 1 = CPU half) |
| window | output | 1 | Timing window inside each half |
| ram_cpu_side | output | 1 | RAM address source (1 = CPU, 0 = video) |
| ram_we_n | output | 1 | Active-low RAM write enable |
| cpu_addr | input | 12 | CPU address |
| cpu_as | input | 1 | Address strobe, captured in the E-low half |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_sel | input | 1 | External decode: the address lies in the RAM range |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data |
| vid_addr | input | 12 | Video fetch address |
| vid_data | output | 8 | Video fetched data |
| hs_n_in | input | 1 | Horizontal sync from the display timing, active low |
| hs_n_out | output | 1 | Window-qualified horizontal sync, active low |

## Verification
The assertions assume that `cpu_rw`, `cpu_sel` and `cpu_wdata` do not change during an E-high half. They also assume that `hs_n_in` stays high for at least one full E half between pulses, so that a new falling edge never arrives while an earlier one is still pending. The stimulus changes the CPU controls only at tick 0. It scrambles `cpu_addr` only after the latch has closed. It spaces sync pulses at least six ticks apart while placing them at arbitrary phases, including one-tick pulses that end before their release.

// File: rtl/vram_pkg.sv
package vram_pkg;
   typedef enum logic {
      SRC_VIDEO = 1'b0,
      SRC_CPU   = 1'b1
   } ram_src_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/vram_timing.sv
module vram_timing #(
   parameter int unsigned HALF_TICKS = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic e_high,
   output logic win,
   output logic last_low,
   output logic last_high
);
   localparam int unsigned CW = $clog2(2 * HALF_TICKS);
   localparam logic [CW-1:0] HALF = CW'(HALF_TICKS);
   localparam logic [CW-1:0] LAST = CW'(2 * HALF_TICKS - 1);
   localparam logic [CW-1:0] WIN_HI = CW'(HALF_TICKS - 2);

   if (HALF_TICKS < 3) begin : g_bad_half
      $error("HALF_TICKS must be at least 3 so the window sits inside each half");
   end

   logic [CW-1:0] tick;
   logic [CW-1:0] pos;

   always_ff @(posedge clk) begin
      if (!rst_n)            tick <= '0;
      else if (tick == LAST) tick <= '0;
      else                   tick <= tick + 1'b1;
   end

   always_comb begin
      e_high    = (tick >= HALF);
      pos       = e_high ? (tick - HALF) : tick;
      win       = (pos >= CW'(1)) && (pos <= WIN_HI);
      last_low  = (tick == HALF - 1'b1);
      last_high = (tick == LAST);
   end

   // R2: the window never spans an E transition
   assert_win_inside_half_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      win |-> (e_high == $past(e_high)));
   // R1: E rises right after the last low tick
   assert_e_rises_after_low_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      last_low |=> e_high);
endmodule

// File: rtl/vram_addr_mux.sv
module vram_addr_mux
   import vram_pkg::*;
#(
   parameter int unsigned AW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          e_high,
   input  logic          cpu_as,
   input  logic [AW-1:0] cpu_addr,
   input  logic [AW-1:0] vid_addr,
   output ram_src_e      src,
   output logic [AW-1:0] ram_addr
);
   logic [AW-1:0] cpu_lat;

   always_ff @(posedge clk) begin
      if (!rst_n)                  cpu_lat <= '0;
      else if (cpu_as && !e_high)  cpu_lat <= cpu_addr;
   end

   always_comb begin
      src      = e_high ? SRC_CPU : SRC_VIDEO;
      ram_addr = (src == SRC_CPU) ? cpu_lat : vid_addr;
   end

   // R4: latched CPU address is frozen while the CPU owns the RAM
   assert_latch_frozen_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (e_high && $past(e_high)) |-> $stable(cpu_lat));
endmodule

// File: rtl/vram_banks.sv
module vram_banks #(
   parameter int unsigned BANK_AW = 11,
   parameter int unsigned NBANK   = 2,
   parameter int unsigned DW      = 8
) (
   input  logic                              clk,
   input  logic [BANK_AW+$clog2(NBANK)-1:0]  addr,
   input  logic                              we,
   input  logic [DW-1:0]                     wdata,
   output logic [DW-1:0]                     rdata
);
   localparam int unsigned SW = $clog2(NBANK);
   localparam int unsigned DEPTH = 1 << BANK_AW;

   if (!vram_pkg::is_pow2(NBANK) || NBANK < 2) begin : g_bad_nbank
      $error("NBANK must be a power of two, at least 2");
   end

   logic [SW-1:0]      bsel;
   logic [BANK_AW-1:0] off;
   logic [DW-1:0]      bank_rd [NBANK];

   assign bsel = addr[BANK_AW +: SW];
   assign off  = addr[BANK_AW-1:0];

   for (genvar g = 0; g < NBANK; g++) begin : g_bank
      logic [DW-1:0] mem [DEPTH];
      always_ff @(posedge clk) begin
         if (we && (bsel == SW'(g))) mem[off] <= wdata;
      end
      assign bank_rd[g] = mem[off];
   end

   assign rdata = bank_rd[bsel];
endmodule

// File: rtl/vram_hsync_qual.sv
module vram_hsync_qual (
   input  logic clk,
   input  logic rst_n,
   input  logic win,
   input  logic hs_n_in,
   output logic hs_n_out
);
   logic hs_q;
   logic pend;
   logic fall;
   logic release_now;

   assign fall        = hs_q && !hs_n_in;
   assign release_now = win && (pend || fall);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hs_q     <= 1'b1;
         pend     <= 1'b0;
         hs_n_out <= 1'b1;
      end else begin
         hs_q <= hs_n_in;
         pend <= (pend || fall) && !release_now;
         if (release_now)  hs_n_out <= 1'b0;
         else if (hs_n_in) hs_n_out <= 1'b1;
      end
   end

   // R10: qualified sync only falls out of a window tick
   assert_sync_in_window_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hs_n_out) |-> $past(win));
   // R11: a pending edge is kept until a window opens
   assert_pending_kept_R11 : assert property (@(posedge clk) disable iff (!rst_n)
      (pend && !win) |=> pend);
endmodule

// File: rtl/shared_vram_ctrl.sv
module shared_vram_ctrl
   import vram_pkg::*;
#(
   parameter int unsigned BANK_AW    = 11,
   parameter int unsigned NBANK      = 2,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned HALF_TICKS = 4,
   parameter int unsigned ADDR_W     = BANK_AW + $clog2(NBANK)
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              e_clk,
   output logic              window,
   output logic              ram_cpu_side,
   output logic              ram_we_n,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic              cpu_as,
   input  logic              cpu_rw,
   input  logic              cpu_sel,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   input  logic [ADDR_W-1:0] vid_addr,
   output logic [DATA_W-1:0] vid_data,
   input  logic              hs_n_in,
   output logic              hs_n_out
);
   if (ADDR_W != BANK_AW + $clog2(NBANK)) begin : g_bad_aw
      $error("ADDR_W must equal BANK_AW plus the bank select width");
   end

   logic              e_high, win, last_low, last_high;
   ram_src_e          src;
   logic [ADDR_W-1:0] ram_addr;
   logic [DATA_W-1:0] ram_rd;
   logic              we;

   vram_timing #(.HALF_TICKS(HALF_TICKS)) u_timing (
      .clk       (clk),
      .rst_n     (rst_n),
      .e_high    (e_high),
      .win       (win),
      .last_low  (last_low),
      .last_high (last_high)
   );

   vram_addr_mux #(.AW(ADDR_W)) u_mux (
      .clk      (clk),
      .rst_n    (rst_n),
      .e_high   (e_high),
      .cpu_as   (cpu_as),
      .cpu_addr (cpu_addr),
      .vid_addr (vid_addr),
      .src      (src),
      .ram_addr (ram_addr)
   );

   assign we = e_high && win && cpu_sel && !cpu_rw;

   vram_banks #(.BANK_AW(BANK_AW), .NBANK(NBANK), .DW(DATA_W)) u_banks (
      .clk   (clk),
      .addr  (ram_addr),
      .we    (we),
      .wdata (cpu_wdata),
      .rdata (ram_rd)
   );

   vram_hsync_qual u_hsync (
      .clk      (clk),
      .rst_n    (rst_n),
      .win      (win),
      .hs_n_in  (hs_n_in),
      .hs_n_out (hs_n_out)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vid_data  <= '0;
         cpu_rdata <= '0;
      end else begin
         if (last_low) vid_data <= ram_rd;
         if (last_high && cpu_sel && cpu_rw) cpu_rdata <= ram_rd;
      end
   end

   assign e_clk        = e_high;
   assign window       = win;
   assign ram_cpu_side = (src == SRC_CPU);
   assign ram_we_n     = !we;

   // R6: a write pulse only occurs inside the window of the CPU half
   assert_we_in_window_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      !ram_we_n |-> (window && e_clk));
   // R3: the video address never drives the RAM during a write
   assert_we_cpu_source_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      !ram_we_n |-> ram_cpu_side);
   // R7: out-of-range accesses never write
   assert_no_we_out_of_range_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_sel |-> ram_we_n);
   // R9: CPU read data only changes after the last CPU tick
   assert_rdata_timing_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cpu_rdata) |-> $past(last_high));
   // R8: video data only changes after the last video tick
   assert_vdata_timing_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(vid_data) |-> $past(last_low));
endmodule

// File: tb/sim_shared_vram_ctrl.sv
module sim_shared_vram_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        e_clk, window, ram_cpu_side, ram_we_n;
   logic [11:0] cpu_addr = '0;
   logic        cpu_as = 1'b0;
   logic        cpu_rw = 1'b1;
   logic        cpu_sel = 1'b0;
   logic [7:0]  cpu_wdata = '0;
   logic [7:0]  cpu_rdata;
   logic [11:0] vid_addr = '0;
   logic [7:0]  vid_data;
   logic        hs_n_in = 1'b1;
   logic        hs_n_out;

   int nchk = 0;
   int nerr = 0;
   int tk = 0;
   bit running = 1'b0;
   bit hs_run = 1'b1;
   int in_falls = 0;
   int out_falls = 0;

   logic [7:0]  model [4096];
   bit          known [4096];
   logic [7:0]  last_cpu = '0;
   logic [19:0] vq [$];
   logic [19:0] cq [$];

   always #10 clk = ~clk;

   shared_vram_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .e_clk(e_clk), .window(window),
      .ram_cpu_side(ram_cpu_side), .ram_we_n(ram_we_n),
      .cpu_addr(cpu_addr), .cpu_as(cpu_as), .cpu_rw(cpu_rw), .cpu_sel(cpu_sel),
      .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
      .vid_addr(vid_addr), .vid_data(vid_data),
      .hs_n_in(hs_n_in), .hs_n_out(hs_n_out)
   );

   always @(posedge clk) begin
      if (!rst_n) tk <= 0;
      else        tk <= (tk + 1) % 8;
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic wait_tick(input int t);
      do @(negedge clk); while (tk != t);
   endtask

   task automatic bus_cycle(input logic [11:0] va, input logic [11:0] ca,
                            input logic rw, input logic sel, input logic [7:0] wd);
      wait_tick(0);
      vid_addr  = va;
      cpu_addr  = ca;
      cpu_as    = 1'b1;
      cpu_rw    = rw;
      cpu_sel   = sel;
      cpu_wdata = wd;
      if (known[va]) vq.push_back({va, model[va]});
      wait_tick(3);
      cpu_as = 1'b0;
      wait_tick(4);
      cpu_addr = 12'($urandom);  // R4: scrambled after the latch closed
      vid_addr = 12'($urandom);
      wait_tick(7);
      if (sel && !rw) begin
         model[ca] = wd;
         known[ca] = 1'b1;
      end else if (rw) begin
         if (sel) begin
            if (known[ca]) begin
               cq.push_back({ca, model[ca]});
               last_cpu = model[ca];
            end
         end else begin
            cq.push_back({ca, last_cpu});  // R7: read outside the range holds cpu_rdata
         end
      end
   endtask

   // scoreboard monitor and timing checks
   always @(negedge clk) begin
      if (running) begin
         chk(e_clk == (tk >= 4), "R1 e_clk", 32'(e_clk), 32'(tk >= 4));
         chk(window == ((tk % 4 == 1) || (tk % 4 == 2)), "R2 window", 32'(window), 32'(tk));
         chk(ram_cpu_side == (tk >= 4), "R3 source", 32'(ram_cpu_side), 32'(tk >= 4));
         chk(ram_we_n == !((tk == 5 || tk == 6) && cpu_sel && !cpu_rw), "R6 we_n",
             32'(ram_we_n), 32'(!((tk == 5 || tk == 6) && cpu_sel && !cpu_rw)));
         if (!cpu_sel) chk(ram_we_n == 1'b1, "R7 we_n out of range", 32'(ram_we_n), 32'd1);
         if (tk == 4 && vq.size() > 0) begin
            logic [19:0] e;
            e = vq.pop_front();
            chk(vid_data == e[7:0], "R8 R5 vid_data", 32'(vid_data), 32'(e[7:0]));
         end
         if (tk == 0 && cq.size() > 0) begin
            logic [19:0] e;
            e = cq.pop_front();
            chk(cpu_rdata == e[7:0], "R9 R4 R5 cpu_rdata", 32'(cpu_rdata), 32'(e[7:0]));
         end
      end
   end

   // sync monitor
   logic hs_in_prev = 1'b1, hs_out_prev = 1'b1;
   int   tk_prev = 0;
   always @(negedge clk) begin
      if (running) begin
         if (hs_in_prev && !hs_n_in) in_falls++;
         if (hs_out_prev && !hs_n_out) begin
            out_falls++;
            chk((tk_prev % 4 == 1) || (tk_prev % 4 == 2), "R10 sync fall in window",
                32'(tk_prev), 32'd1);
         end
      end
      hs_in_prev  = hs_n_in;
      hs_out_prev = hs_n_out;
      tk_prev     = tk;
   end

   // sync driver: pulses at arbitrary phases
   initial begin
      wait (running);
      while (hs_run) begin
         repeat (6 + ($urandom % 30)) @(negedge clk);
         if (!hs_run) break;
         hs_n_in = 1'b0;
         repeat (1 + ($urandom % 12)) @(negedge clk);
         hs_n_in = 1'b1;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      nerr++;
      nchk++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      for (int i = 0; i < 4096; i++) known[i] = 1'b0;
      repeat (3) @(negedge clk);
      chk(e_clk == 1'b0, "R1 reset e_clk", 32'(e_clk), 32'd0);
      chk(ram_we_n == 1'b1, "R6 reset we_n", 32'(ram_we_n), 32'd1);
      chk(hs_n_out == 1'b1, "R11 reset hs_n_out", 32'(hs_n_out), 32'd1);
      chk(cpu_rdata == 8'h00, "R9 reset cpu_rdata", 32'(cpu_rdata), 32'd0);
      rst_n = 1'b1;
      running = 1'b1;
      // fill both banks; video trails one address behind
      for (int a = 0; a < 4096; a++)
         bus_cycle(12'(a == 0 ? 0 : a - 1), 12'(a), 1'b0, 1'b1, 8'(a * 7) ^ 8'(a >> 4));
      // random mixed traffic, one quarter outside the range
      for (int n = 0; n < 800; n++)
         bus_cycle(12'($urandom), 12'($urandom), 1'($urandom), ($urandom % 4) != 0, 8'($urandom));
      // R5: distinct bytes at locations differing only in bit 11
      bus_cycle(12'h000, 12'h123, 1'b0, 1'b1, 8'hA5);
      bus_cycle(12'h000, 12'h923, 1'b0, 1'b1, 8'h5A);
      bus_cycle(12'h923, 12'h123, 1'b1, 1'b1, 8'h00);
      // R7: an out-of-range write leaves the location intact
      bus_cycle(12'h000, 12'h123, 1'b0, 1'b0, 8'hFF);
      bus_cycle(12'h123, 12'h123, 1'b1, 1'b1, 8'h00);
      // full read-back through both sides
      for (int a = 0; a < 4096; a++)
         bus_cycle(12'(4095 - a), 12'(a), 1'b1, 1'b1, 8'h00);
      wait_tick(4);
      hs_run = 1'b0;
      hs_n_in = 1'b1;
      repeat (40) @(negedge clk);
      chk(in_falls == out_falls, "R11 every sync edge passed", 32'(out_falls), 32'(in_falls));
      chk(in_falls > 20, "R11 sync stimulus present", 32'(in_falls), 32'd20);
      chk(hs_n_out == 1'b1, "R11 sync idle high", 32'(hs_n_out), 32'd1);
      chk(vq.size() == 0 && cq.size() == 0, "R8 R9 scoreboard drained",
          32'(vq.size() + cq.size()), 32'd0);
      running = 1'b0;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule